// File: doc/BRIEF.md
# Per-Hart Software Interrupt Bank

This block holds one software interrupt pending flag for each hart of a cluster and drives each flag straight onto that hart's software interrupt line. Software reaches the flags through a small 32-bit register bus. Each hart owns one word, and the words are packed from offset zero upward. Any agent can raise an inter-processor interrupt by writing a one into the target hart's word.

A build-time mode parameter sets the semantics. In machine mode a word behaves as a normal read/write flag: writing zero lowers the line, and a read returns the flag. In supervisor mode a word can only send a set pulse, and reads always return zero. The hart acknowledges the interrupt through a per-hart clear input. The bit index of each interrupt and clear pin equals the number of the hart it serves, starting at a configurable first hart number.

Top module: `swi_bank`

## Requirements
- R1: After reset every interrupt output is low.
- R2: The word for the hart with local index i sits at byte offset 4*i. Offsets at or above 4*NUM_HARTS are unmapped: a write there changes no output, and a read there returns zero.
- R3: A valid word write with data bit 0 = 1 to a mapped word raises that hart's interrupt from the clock edge that takes the write. Data bits 31..1 have no effect.
- R4: In machine mode (SUPERVISOR=0), a valid word write with data bit 0 = 0 lowers that hart's interrupt at the edge that takes the write.
- R5: In supervisor mode (SUPERVISOR=1), a write with data bit 0 = 0 leaves the interrupt unchanged.
- R6: In machine mode, a valid word read of a mapped word returns the hart's pending flag in bit 0 and zero in bits 31..1, in the same cycle as the request. Read data is zero when no read is requested.
- R7: In supervisor mode every read returns zero.
- R8: An access is valid only when req_size = 2'b10 (32-bit) and req_addr[1:0] = 0. Any other access reads zero and its write is dropped.
- R9: In supervisor mode, hart_clr for a hart lowers that hart's interrupt at the next edge. In machine mode hart_clr is ignored.
- R10: When a set write and hart_clr target the same hart in the same cycle, the set wins and the interrupt is high afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Combinational read data |
| hart_clr | input | NUM_HARTS (bits FIRST_HART and up) | Per-hart acknowledge, used in supervisor mode only |
| irq | output | NUM_HARTS (bits FIRST_HART and up) | Per-hart software interrupt lines |

## Verification
The bench builds two copies on the same bus: one in machine mode and one in supervisor mode. Both use three harts, first hart number 2 and a 6-bit address. With three harts, the mapped words end partway through the 64-byte space, and the unmapped offsets include one that is not a power-of-two boundary. The 6-bit address lets the bench sweep every offset with every access size and with data patterns that differ in bit 0 and in the upper bits. Because the two copies share one bus, each stimulus shows machine and supervisor semantics side by side, including the acknowledge inputs and the set-wins collision.

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int NUM_HARTS  = 4,
  parameter int FIRST_HART = 0,
  parameter bit SUPERVISOR = 1'b0,
  parameter int ADDR_W     = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  input  logic                                   req_write,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic [1:0]                             req_size,
  input  logic [31:0]                            req_wdata,
  output logic [31:0]                            rsp_rdata,
  input  logic [FIRST_HART+NUM_HARTS-1:FIRST_HART] hart_clr,
  output logic [FIRST_HART+NUM_HARTS-1:FIRST_HART] irq
);

  localparam int SEL_W = ADDR_W - 2;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  logic [SEL_W-1:0]     sel;
  logic                 acc_ok;
  logic [NUM_HARTS-1:0] sel_oh;
  logic [NUM_HARTS-1:0] pend;
  logic [NUM_HARTS-1:0] clr_in;
  logic                 wr_go;
  logic                 rd_go;

  assign sel    = req_addr[ADDR_W-1:2];
  assign acc_ok = req_valid && (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);
  assign wr_go  = acc_ok && req_write;
  assign rd_go  = acc_ok && !req_write;
  assign clr_in = hart_clr;
  assign irq    = pend;

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    logic set_i, clr_i;
    assign sel_oh[i] = acc_ok && (sel == SEL_W'(i));
    assign set_i     = wr_go && sel_oh[i] && req_wdata[0];
    if (SUPERVISOR) begin : g_sup
      assign clr_i = clr_in[i];
    end else begin : g_mach
      assign clr_i = wr_go && sel_oh[i] && !req_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend[i] <= 1'b0;
      else if (set_i) pend[i] <= 1'b1;
      else if (clr_i) pend[i] <= 1'b0;
    end

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && sel_oh[i] && req_wdata[0]) |=> pend[i]);

    if (SUPERVISOR) begin : g_sup_chk
      assert_zero_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[i] && !clr_in[i]) |=> pend[i]);
      assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in[i] && !(wr_go && sel_oh[i] && req_wdata[0])) |=> !pend[i]);
    end else begin : g_mach_chk
      assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && sel_oh[i] && !req_wdata[0]) |=> !pend[i]);
    end
  end

  if (SUPERVISOR) begin : g_rd_sup
    assign rsp_rdata = 32'h0;
  end else begin : g_rd_mach
    assign rsp_rdata = {31'h0, rd_go && |(sel_oh & pend)};
  end

  assert_unmapped_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (sel_oh == '0) && (hart_clr == '0)) |=> $stable(irq));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_ok && (hart_clr == '0)) |=> $stable(irq));

  assert_read_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

endmodule

// File: tb/swi_bank_test.sv
module swi_bank_test;
  localparam int NH = 3;
  localparam int FH = 2;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'b10;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_m, rd_s;
  logic [FH+NH-1:FH] clr_m = '0, clr_s = '0;
  logic [FH+NH-1:FH] irq_m, irq_s;
  logic [NH-1:0] exp_m = '0, exp_s = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  swi_bank #(.NUM_HARTS(NH), .FIRST_HART(FH), .SUPERVISOR(1'b0), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rd_m), .hart_clr(clr_m), .irq(irq_m));

  swi_bank #(.NUM_HARTS(NH), .FIRST_HART(FH), .SUPERVISOR(1'b1), .ADDR_W(AW)) uut_sup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rd_s), .hart_clr(clr_s), .irq(irq_s));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit hit(int a, int sz);
    return sz == 2 && (a % 4) == 0 && (a / 4) < NH;
  endfunction

  task automatic wr(int a, int sz, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_size = 2'(sz); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    if (hit(a, sz)) begin
      if (d[0]) begin exp_m[a/4] = 1; exp_s[a/4] = 1; end
      else exp_m[a/4] = 0;
    end
  endtask

  task automatic rd(int a, int sz);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(a); req_size = 2'(sz);
    #1;
    check((sz == 2 && a % 4 != 0) ? "R8 mach read" : "R6 mach read", rd_m,
          hit(a, sz) ? {31'h0, exp_m[a/4]} : 32'h0);
    check("R7 sup read", rd_s, 32'h0);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0001; pats[1] = 32'hFFFF_FFFE;
    pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;
    repeat (3) @(negedge clk);
    check("R1 reset mach", 32'(irq_m), 32'h0);
    check("R1 reset sup", 32'(irq_s), 32'h0);
    rst_n = 1;
    check("R6 idle read", rd_m, 32'h0);

    for (int a = 0; a < 64; a++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int p = 0; p < 4; p++) begin
          wr(a, sz, pats[p]);
          check(!hit(a, sz) ? "R2/R8 dropped mach" : (pats[p][0] ? "R3 set mach" : "R4 clear mach"),
                32'(irq_m), 32'(exp_m));
          check(!hit(a, sz) ? "R2/R8 dropped sup" : (pats[p][0] ? "R3 set sup" : "R5 zero ignored sup"),
                32'(irq_s), 32'(exp_s));
        end
      end
      if (a % 8 == 0) wr(a, 2, 32'h1);
      @(negedge clk);
      clr_m = '1; clr_s = '1;
      @(negedge clk);
      clr_m = '0; clr_s = '0;
      exp_s = '0;
      check("R9 ack clears sup", 32'(irq_s), 32'h0);
      check("R9 ack ignored mach", 32'(irq_m), 32'(exp_m));
    end

    wr(0, 2, 32'h1); wr(4, 2, 32'h0); wr(8, 2, 32'h3);
    for (int a = 0; a < 64; a++)
      for (int sz = 0; sz < 4; sz++) rd(a, sz);
    wr(4, 2, 32'h1); wr(0, 2, 32'h0);
    for (int a = 0; a < 12; a += 4) rd(a, 2);

    wr(0, 2, 32'hFFFF_FFFF);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 6'd4; req_size = 2'b10; req_wdata = 32'h1;
    clr_s = 3'b111;
    @(negedge clk);
    req_valid = 0; req_write = 0; clr_s = '0;
    check("R10 set beats ack", 32'(irq_s), 32'b010);
    check("R9 others acked", 32'(irq_s[FH]), 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule